// File: doc/BRIEF.md
# Capture-only boundary-scan test port controller

This block is a serial test port controller built around the standard sixteen-state test-port state machine. It is clocked by the test clock and steered by the mode-select input. It owns a three-bit instruction register and three data registers: a one-bit skip register, a 32-bit identity register holding a fixed code, and a capture-only boundary register of parameterized length. The boundary register snapshots a parallel bus of device pin values.

A board-level tester shifts an opcode in, then moves to the data path to read the selected register out least-significant bit first. The boundary register never drives pins. Pin values can be sampled but not preloaded or updated. Two of the opcodes also raise a flag that floats the device's functional outputs. Opcodes without a defined function select the skip register.

Top module: `scan_port_ctrl`

## Requirements
- R1: After the asynchronous power-on reset the controller is in Test-Logic-Reset, the serial output enable and the float flag are low, and the active instruction is the identity opcode 001.
- R2: Five consecutive rising test-clock edges with mode-select high bring the state machine to Test-Logic-Reset from any state, and this restores opcode 001 and clears the float flag.
- R3: In Capture-IR the instruction shift register loads 001, so the first three bits shifted out are 1, 0, 0.
- R4: Under opcode 001, Capture-DR loads the 32-bit identity code with bit 0 forced to 1, and the code is shifted out bit 0 first.
- R5: Opcode 111, and the unused opcodes 011, 101 and 110, select a single-bit register that captures 0, so serial output lags serial input by exactly one shift.
- R6: Opcode 100 (sample) captures the pin bus into the boundary register in Capture-DR, shifts it out pin 0 first, and leaves the float flag low.
- R7: Opcode 000 (external test) captures the pins exactly as the sample opcode does and holds the float flag high.
- R8: Opcode 010 (sample with float) selects the boundary register, captures the pins and holds the float flag high.
- R9: Update-DR has no effect on the pins under the sample opcode: the float flag is unchanged and the next capture returns the live pin bus, not the shifted-in data.
- R10: Serial input enters the most significant bit of the selected register and serial output comes from its least significant bit, so data shifted past the full register length reappears at the output.
- R11: The serial output enable is high only while in Shift-IR or Shift-DR, and the serial output changes only on falling test-clock edges.
- R12: A new instruction takes effect on the falling edge in Update-IR, and the float flag shows the old instruction while in Exit1-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pins_i | input | BND_W | Parallel pin values for boundary capture |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Serial output drive enable |
| pins_hiz | output | 1 | Request to float the device functional outputs |

## Verification
Two functions can fall in the same half-cycle. One is the instruction change on the falling edge of Update-IR, which moves the float flag and the register selection. The other is the serial output update on that same falling edge. The bench provokes this by loading the float-forcing opcodes straight after shifting out the captured pattern, then sampling the float flag in Exit1-IR and again in Update-IR, so that an early or late switch shows up. A second overlap is the mode-select escape: five mode-select highs given in the middle of Shift-DR under a floating opcode must clear the float flag and restore the identity read.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [3:0] {
        ST_RESET  = 4'd0,
        ST_IDLE   = 4'd1,
        ST_SELDR  = 4'd2,
        ST_CAPDR  = 4'd3,
        ST_SHDR   = 4'd4,
        ST_EX1DR  = 4'd5,
        ST_PAUDR  = 4'd6,
        ST_EX2DR  = 4'd7,
        ST_UPDR   = 4'd8,
        ST_SELIR  = 4'd9,
        ST_CAPIR  = 4'd10,
        ST_SHIR   = 4'd11,
        ST_EX1IR  = 4'd12,
        ST_PAUIR  = 4'd13,
        ST_EX2IR  = 4'd14,
        ST_UPIR   = 4'd15
    } port_state_e;

    typedef enum logic [1:0] {
        SEL_SKIP = 2'd0,
        SEL_IDENT = 2'd1,
        SEL_BOUND = 2'd2
    } dr_sel_e;

    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_EXT    = 3'b000;
    localparam logic [OP_W-1:0] OP_IDENT  = 3'b001;
    localparam logic [OP_W-1:0] OP_SAMPZ  = 3'b010;
    localparam logic [OP_W-1:0] OP_SAMPLE = 3'b100;
    localparam logic [OP_W-1:0] OP_SKIP   = 3'b111;
    localparam logic [OP_W-1:0] OP_CAP_PATTERN = 3'b001;

    function automatic port_state_e step_state(input port_state_e s, input logic m);
        port_state_e n;
        case (s)
            ST_RESET: n = m ? ST_RESET : ST_IDLE;
            ST_IDLE:  n = m ? ST_SELDR : ST_IDLE;
            ST_SELDR: n = m ? ST_SELIR : ST_CAPDR;
            ST_CAPDR: n = m ? ST_EX1DR : ST_SHDR;
            ST_SHDR:  n = m ? ST_EX1DR : ST_SHDR;
            ST_EX1DR: n = m ? ST_UPDR  : ST_PAUDR;
            ST_PAUDR: n = m ? ST_EX2DR : ST_PAUDR;
            ST_EX2DR: n = m ? ST_UPDR  : ST_SHDR;
            ST_UPDR:  n = m ? ST_SELDR : ST_IDLE;
            ST_SELIR: n = m ? ST_RESET : ST_CAPIR;
            ST_CAPIR: n = m ? ST_EX1IR : ST_SHIR;
            ST_SHIR:  n = m ? ST_EX1IR : ST_SHIR;
            ST_EX1IR: n = m ? ST_UPIR  : ST_PAUIR;
            ST_PAUIR: n = m ? ST_EX2IR : ST_PAUIR;
            ST_EX2IR: n = m ? ST_UPIR  : ST_SHIR;
            default:  n = m ? ST_SELDR : ST_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
(
    input  logic        tck,
    input  logic        rst_n,
    input  logic        tms,
    output port_state_e state_o
);
    localparam int ESC_LEN = 5;
    localparam int ESC_W   = $clog2(ESC_LEN + 1);

    typedef struct packed {
        port_state_e        st;
        logic [ESC_W-1:0]   ones;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.st = step_state(r_q.st, tms);
        if (!tms)
            r_d.ones = '0;
        else if (r_q.ones != ESC_W'(ESC_LEN))
            r_d.ones = r_q.ones + ESC_W'(1);
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_RESET;
            r_q.ones <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;

    assert_escape_reset_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (r_q.ones == ESC_W'(ESC_LEN)) |-> (r_q.st == ST_RESET));

    assert_hold_reset_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (r_q.st == ST_RESET && tms) |=> (r_q.st == ST_RESET));

endmodule

// File: rtl/scan_ir.sv
module scan_ir
    import scan_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  port_state_e     state_i,
    input  logic            tdi,
    output logic            ir_lsb_o,
    output dr_sel_e         sel_o,
    output logic            hiz_o
);
    logic [OP_W-1:0] sh_d, sh_q;
    logic [OP_W-1:0] op_d, op_q;

    always_comb begin
        sh_d = sh_q;
        op_d = op_q;
        case (state_i)
            ST_CAPIR: sh_d = OP_CAP_PATTERN;
            ST_SHIR:  sh_d = {tdi, sh_q[OP_W-1:1]};
            default:  sh_d = sh_q;
        endcase
        if (state_i == ST_UPIR)
            op_d = sh_q;
        else if (state_i == ST_RESET)
            op_d = OP_IDENT;
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) sh_q <= OP_CAP_PATTERN;
        else        sh_q <= sh_d;
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) op_q <= OP_IDENT;
        else        op_q <= op_d;
    end

    always_comb begin
        case (op_q)
            OP_IDENT:              sel_o = SEL_IDENT;
            OP_EXT, OP_SAMPZ,
            OP_SAMPLE:             sel_o = SEL_BOUND;
            default:               sel_o = SEL_SKIP;
        endcase
        hiz_o = (op_q == OP_EXT) || (op_q == OP_SAMPZ);
    end

    assign ir_lsb_o = sh_q[0];

    assert_capture_pattern_R3: assert property (@(posedge tck) disable iff (!rst_n)
        (state_i == ST_CAPIR) |=> (sh_q[1:0] == 2'b01));

    assert_op_stable_R12: assert property (@(posedge tck) disable iff (!rst_n)
        !(state_i == ST_UPIR || state_i == ST_RESET) |-> $stable(op_q));

endmodule

// File: rtl/scan_dr.sv
module scan_dr
    import scan_pkg::*;
#(
    parameter int          BND_W  = 84,
    parameter logic [31:0] ID_VAL = 32'h0000_0001
) (
    input  logic             tck,
    input  logic             rst_n,
    input  port_state_e      state_i,
    input  dr_sel_e          sel_i,
    input  logic             tdi,
    input  logic [BND_W-1:0] pins_i,
    output logic             dr_lsb_o
);
    localparam int ID_W = 32;
    localparam logic [ID_W-1:0] ID_CAP = {ID_VAL[ID_W-1:1], 1'b1};

    typedef struct packed {
        logic             skip;
        logic [ID_W-1:0]  ident;
        logic [BND_W-1:0] bound;
    } dr_regs_t;

    dr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (state_i == ST_CAPDR) begin
            case (sel_i)
                SEL_IDENT: r_d.ident = ID_CAP;
                SEL_BOUND: r_d.bound = pins_i;
                default:   r_d.skip  = 1'b0;
            endcase
        end else if (state_i == ST_SHDR) begin
            case (sel_i)
                SEL_IDENT: r_d.ident = {tdi, r_q.ident[ID_W-1:1]};
                SEL_BOUND: r_d.bound = {tdi, r_q.bound[BND_W-1:1]};
                default:   r_d.skip  = tdi;
            endcase
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            r_q.skip  <= 1'b0;
            r_q.ident <= ID_CAP;
            r_q.bound <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (sel_i)
            SEL_IDENT: dr_lsb_o = r_q.ident[0];
            SEL_BOUND: dr_lsb_o = r_q.bound[0];
            default:   dr_lsb_o = r_q.skip;
        endcase
    end

    assert_ident_bit0_R4: assert property (@(posedge tck) disable iff (!rst_n)
        (state_i == ST_CAPDR && sel_i == SEL_IDENT) |=> r_q.ident[0]);

    assert_skip_zero_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (state_i == ST_CAPDR && sel_i == SEL_SKIP) |=> !r_q.skip);

    assert_bound_capture_R6: assert property (@(posedge tck) disable iff (!rst_n)
        (state_i == ST_CAPDR && sel_i == SEL_BOUND) |=> (r_q.bound == $past(pins_i)));

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
    import scan_pkg::*;
#(
    parameter int          BND_W  = 84,
    parameter logic [31:0] ID_VAL = 32'h0000_0001
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BND_W-1:0] pins_i,
    output logic             tdo,
    output logic             tdo_oe,
    output logic             pins_hiz
);
    typedef struct packed {
        logic dout;
        logic oe;
    } out_regs_t;

    port_state_e state;
    dr_sel_e     sel;
    logic        ir_lsb;
    logic        dr_lsb;
    out_regs_t   o_d, o_q;

    scan_fsm u_fsm (
        .tck     (tck),
        .rst_n   (rst_n),
        .tms     (tms),
        .state_o (state)
    );

    scan_ir u_ir (
        .tck      (tck),
        .rst_n    (rst_n),
        .state_i  (state),
        .tdi      (tdi),
        .ir_lsb_o (ir_lsb),
        .sel_o    (sel),
        .hiz_o    (pins_hiz)
    );

    scan_dr #(
        .BND_W  (BND_W),
        .ID_VAL (ID_VAL)
    ) u_dr (
        .tck      (tck),
        .rst_n    (rst_n),
        .state_i  (state),
        .sel_i    (sel),
        .tdi      (tdi),
        .pins_i   (pins_i),
        .dr_lsb_o (dr_lsb)
    );

    always_comb begin
        o_d.oe = (state == ST_SHIR) || (state == ST_SHDR);
        if (state == ST_SHIR)
            o_d.dout = ir_lsb;
        else if (state == ST_SHDR)
            o_d.dout = dr_lsb;
        else
            o_d.dout = 1'b0;
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            o_q.dout <= 1'b0;
            o_q.oe   <= 1'b0;
        end else begin
            o_q <= o_d;
        end
    end

    assign tdo    = o_q.dout;
    assign tdo_oe = o_q.oe;

    assert_oe_in_shift_R11: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe |-> (state == ST_SHIR || state == ST_SHDR));

    assert_reset_clears_hiz_R1: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET) |=> !pins_hiz);

endmodule

// File: tb/scan_port_ctrl_bench.sv
module scan_port_ctrl_bench;
    localparam int          BW = 84;
    localparam logic [31:0] IDV = 32'h2B6D_2C4A;
    localparam logic [31:0] ID_EXP = 32'h2B6D_2C4B;

    logic          tck = 1'b0;
    logic          rst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [BW-1:0] pins = '0;
    logic          tdo, tdo_oe, pins_hiz;

    int total = 0;
    int bad = 0;
    logic s_tdo, s_oe, s_hiz, pe_tdo;
    logic edge_err;

    scan_port_ctrl #(.BND_W(BW), .ID_VAL(IDV)) u_scan_port_ctrl (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .pins_i(pins),
        .tdo(tdo), .tdo_oe(tdo_oe), .pins_hiz(pins_hiz)
    );

    always #2 tck = ~tck;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        logic prev;
        prev = s_tdo;
        tms = m;
        tdi = d;
        @(posedge tck);
        #1;
        pe_tdo = tdo;
        if (pe_tdo !== prev) edge_err = 1'b1;
        @(negedge tck);
        #1;
        s_tdo = tdo;
        s_oe  = tdo_oe;
        s_hiz = pins_hiz;
    endtask

    task automatic load_ir(input logic [2:0] op, output logic [2:0] cap,
                           output logic hiz_ex1, output logic hiz_upd);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        cap[0] = s_tdo;
        step(0, op[0]); cap[1] = s_tdo;
        step(0, op[1]); cap[2] = s_tdo;
        step(1, op[2]); hiz_ex1 = s_hiz;
        step(1, 0);     hiz_upd = s_hiz;
        step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] dout,
                           output logic oe_mid, output logic oe_exit);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        dout[0] = s_tdo;
        oe_mid = s_oe;
        for (int i = 1; i < n; i++) begin
            step(0, din[i-1]);
            dout[i] = s_tdo;
        end
        step(1, din[n-1]);
        oe_exit = s_oe;
        step(1, 0); step(0, 0);
    endtask

    task automatic t_reset;
        logic [127:0] o;
        logic a, b;
        chk("R1 oe after reset", 128'(tdo_oe), 128'(0));
        chk("R1 hiz after reset", 128'(pins_hiz), 128'(0));
        s_tdo = tdo;
        step(0, 0);
        chk("R11 oe in idle", 128'(s_oe), 128'(0));
        scan_dr(32, '0, o, a, b);
        chk("R1 R4 identity code", o[31:0], 128'(ID_EXP));
        chk("R4 bit0 is one", 128'(o[0]), 128'(1));
        chk("R11 oe in shift-dr", 128'(a), 128'(1));
        chk("R11 oe in exit1-dr", 128'(b), 128'(0));
    endtask

    task automatic t_ir_capture;
        logic [2:0] c;
        logic h1, h2;
        load_ir(3'b111, c, h1, h2);
        chk("R3 capture pattern", 128'(c), 128'(3'b001));
    endtask

    task automatic t_skip(input logic [2:0] op, input string req);
        logic [2:0] c;
        logic h1, h2, a, b;
        logic [127:0] o;
        logic [127:0] din;
        din = 128'hB5;
        load_ir(op, c, h1, h2);
        chk({req, " hiz low"}, 128'(h2), 128'(0));
        edge_err = 1'b0;
        scan_dr(8, din, o, a, b);
        chk({req, " one-bit lag"}, o[7:0], 128'({din[6:0], 1'b0}));
        chk("R11 tdo only on falling edge", 128'(edge_err), 128'(0));
    endtask

    task automatic t_sample;
        logic [2:0] c;
        logic h1, h2, a, b;
        logic [127:0] o;
        pins = {20'hABCDE, 64'h0123_4567_89AB_CDEF};
        load_ir(3'b100, c, h1, h2);
        chk("R6 hiz low", 128'(h2), 128'(0));
        scan_dr(BW + 8, 128'h5A, o, a, b);
        chk("R6 pins captured", o[BW-1:0], 128'(pins));
        chk("R10 msb in lsb out", 128'(o[BW+7:BW]), 128'(8'h5A));
        chk("R9 hiz after update-dr", 128'(s_hiz), 128'(0));
        pins = {20'h13579, 64'hFEDC_BA98_7654_3210};
        scan_dr(BW, '1, o, a, b);
        chk("R9 recapture is live pins", o[BW-1:0], 128'(pins));
    endtask

    task automatic t_float(input logic [2:0] op, input string req);
        logic [2:0] c;
        logic h1, h2, a, b;
        logic [127:0] o;
        pins = {20'h0F0F0, 64'hA5A5_3C3C_0FF0_1234};
        load_ir(op, c, h1, h2);
        chk("R12 old instr in exit1-ir", 128'(h1), 128'(0));
        chk({req, " hiz high in update-ir"}, 128'(h2), 128'(1));
        scan_dr(BW, '0, o, a, b);
        chk({req, " pins captured"}, o[BW-1:0], 128'(pins));
        chk({req, " hiz held"}, 128'(s_hiz), 128'(1));
    endtask

    task automatic t_escape;
        logic [2:0] c;
        logic h1, h2, a, b;
        logic [127:0] o;
        load_ir(3'b000, c, h1, h2);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        chk("R2 hiz cleared", 128'(s_hiz), 128'(0));
        chk("R2 oe low", 128'(s_oe), 128'(0));
        step(0, 0);
        scan_dr(32, '0, o, a, b);
        chk("R2 identity restored", o[31:0], 128'(ID_EXP));
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        edge_err = 1'b0;
        s_tdo = 1'b0;
        #9;
        rst_n = 1'b1;
        @(negedge tck);
        #1;
        t_reset;
        t_ir_capture;
        t_skip(3'b111, "R5 op111");
        t_skip(3'b011, "R5 op011");
        t_skip(3'b101, "R5 op101");
        t_skip(3'b110, "R5 op110");
        t_sample;
        t_float(3'b000, "R7");
        step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(0, 0);
        t_float(3'b010, "R8");
        t_escape;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule